// File: doc/BRIEF.md
# Streaming 3x3 Gaussian Smoothing Filter

This block cleans sensor noise from a raster stream of grayscale pixels. Pixels arrive one per accepted clock, qualified by a valid flag, and the first pixel of each frame carries a start-of-frame flag. Two row delay lines, each as deep as one image row, give a 3x3 neighbourhood. A fixed binomial kernel is applied through a registered multiply stage and a pipelined adder tree. The block emits exactly one smoothed pixel per input pixel, in raster order. Frame width and height are fixed when the design is elaborated.

The control path is a three-state machine. IDLE waits for a frame. The transition IDLE->RUN fires on a valid pixel with start-of-frame set. RUN accepts the frame's pixels. In RUN, a new start-of-frame restarts the frame (RUN->RUN restart). The transition RUN->FLUSH fires when the last pixel of the frame (bottom row, rightmost column) is accepted. FLUSH then advances the window on its own for one row plus one pixel, so that the bottom row leaves the pipeline. The transition FLUSH->IDLE fires when that drain count is exhausted. Neighbours that fall outside the frame are treated as zero.

Top module: `gauss3_stream`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, and no output appears until a frame is started.
- R2: Each output equals (S + 8) >> 4, where S is the weighted sum of the 3x3 neighbourhood of its pixel. The weights are 4 at the centre, 2 at the four edge-adjacent positions and 1 at the four diagonal positions.
- R3: Neighbour positions outside the frame contribute zero. For a flat image of value v, an output is floor((9v+8)/16) at a corner, floor((12v+8)/16) on a non-corner border pixel and v in the interior.
- R4: A complete frame of IMG_W x IMG_H accepted pixels yields exactly IMG_W x IMG_H outputs, in raster order (row by row, left to right).
- R5: In a gap-free frame whose first pixel is accepted at clock edge n, the first output is registered at edge n + IMG_W + 4. That is the edge that accepts the pixel one row and one column later, plus three pipeline stages.
- R6: Cycles with `in_valid` low freeze the neighbourhood. A frame with idle gaps produces the same output values, in the same order, as the same frame sent without gaps.
- R7: In IDLE, valid pixels whose `in_sof` is 0 are ignored: they produce no output and do not disturb the next frame.
- R8: A start-of-frame during RUN restarts the frame. Outputs already complete for the interrupted frame (centre index up to accepted count minus IMG_W minus 2) are emitted, and are followed by the full output of the new frame.
- R9: During FLUSH (IMG_W+1 cycles after the last pixel), all inputs are ignored, including valid pixels and start-of-frame.
- R10: A frame started right after the drain carries no data over from the previous frame.
- R11: In a gap-free frame, the outputs appear on consecutive cycles, one pixel per clock, with the drain included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pix | input | PIX_W | Incoming grayscale pixel |
| in_valid | input | 1 | Qualifies `in_pix` this cycle |
| in_sof | input | 1 | Marks the first pixel of a frame; used only with `in_valid` |
| out_pix | output | PIX_W | Smoothed pixel |
| out_valid | output | 1 | Qualifies `out_pix` this cycle |

## Verification
The assertions rely on the source not starting a new frame during the drain. The block ignores such a start anyway, so the frame-count property stays true only because the frame that follows begins after FLUSH has ended. The assertions also rely on each frame being either complete or cut short by a fresh start-of-frame. The stimulus drives whole frames, a deliberately truncated frame followed at once by a restart, junk pixels placed exactly inside the drain window, and frames with idle gaps. Each new frame is started at or after the first IDLE cycle.

// File: rtl/g3_pkg.sv
package g3_pkg;

    // Window edge length and the normalisation of the binomial kernel.
    localparam int KDIM       = 3;
    localparam int NORM_SHIFT = 4;
    localparam int ROUND_BIAS = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } g3_state_e;

    // Which window edges lie outside the frame for the current centre.
    typedef struct packed {
        logic top;
        logic bot;
        logic lft;
        logic rgt;
    } g3_border_t;

    // Separable binomial weight: (1 2 1) outer product (1 2 1).
    function automatic int unsigned tap_weight(input int r, input int c);
        int unsigned wr;
        int unsigned wc;
        wr = (r == 1) ? 2 : 1;
        wc = (c == 1) ? 2 : 1;
        return wr * wc;
    endfunction

endpackage

// File: rtl/g3_linebuf.sv
module g3_linebuf #(
    parameter int DEPTH = 640,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] ptr_q;

    // Read-before-write at one circular slot: exactly DEPTH advances of delay.
    assign dout = mem[ptr_q];

    always_ff @(posedge clk) begin
        if (adv) begin
            mem[ptr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_LAST); // R2

endmodule

// File: rtl/g3_window.sv
module g3_window
    import g3_pkg::*;
#(
    parameter int LINE = 640,
    parameter int DW   = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             adv,
    input  logic [DW-1:0]                    din,
    output logic [KDIM-1:0][KDIM-1:0][DW-1:0] win
);
    // tap[KDIM-1] is the newest row, tap[0] the oldest.
    logic [KDIM-1:0][DW-1:0] tap;

    assign tap[KDIM-1] = din;

    for (genvar i = 0; i < KDIM - 1; i++) begin : g_line
        g3_linebuf #(
            .DEPTH (LINE),
            .DW    (DW)
        ) u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .din   (tap[i+1]),
            .dout  (tap[i])
        );
    end

    // Columns shift left on each advance; column KDIM-1 is the newest.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (adv) begin
            for (int r = 0; r < KDIM; r++) begin
                for (int c = 0; c < KDIM - 1; c++) begin
                    win[r][c] <= win[r][c+1];
                end
                win[r][KDIM-1] <= tap[r];
            end
        end
    end

endmodule

// File: rtl/g3_kernel.sv
module g3_kernel
    import g3_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [KDIM-1:0][KDIM-1:0][DW-1:0] win,
    input  logic                             win_vld,
    input  g3_border_t                       border,
    output logic [DW-1:0]                    pix_o,
    output logic                             vld_o
);
    localparam int PROD_W = DW + 2;
    localparam int ROWS_W = DW + 3;
    localparam int SUM_W  = DW + 5;

    logic [PROD_W-1:0] prod_q [KDIM][KDIM];
    logic [ROWS_W-1:0] row_q  [KDIM];
    logic [SUM_W-1:0]  tot_d;
    logic              v1_q;
    logic              v2_q;

    for (genvar r = 0; r < KDIM; r++) begin : g_row
        for (genvar c = 0; c < KDIM; c++) begin : g_col
            localparam int unsigned WT = tap_weight(r, c);
            logic keep;

            assign keep = !((r == 0 && border.top) || (r == KDIM - 1 && border.bot) ||
                            (c == 0 && border.lft) || (c == KDIM - 1 && border.rgt));

            // Stage 1: masked weighted tap.
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    prod_q[r][c] <= '0;
                end else begin
                    prod_q[r][c] <= keep ? PROD_W'(win[r][c]) * PROD_W'(WT) : '0;
                end
            end
        end

        logic [ROWS_W-1:0] row_d;
        always_comb begin
            row_d = '0;
            for (int c = 0; c < KDIM; c++) begin
                row_d = row_d + ROWS_W'(prod_q[r][c]);
            end
        end

        // Stage 2: per-row partial sum.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                row_q[r] <= '0;
            end else begin
                row_q[r] <= row_d;
            end
        end
    end

    always_comb begin
        tot_d = SUM_W'(ROUND_BIAS);
        for (int r = 0; r < KDIM; r++) begin
            tot_d = tot_d + SUM_W'(row_q[r]);
        end
    end

    // Stage 3: rounded normalisation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1_q  <= 1'b0;
            v2_q  <= 1'b0;
            vld_o <= 1'b0;
            pix_o <= '0;
        end else begin
            v1_q  <= win_vld;
            v2_q  <= v1_q;
            vld_o <= v2_q;
            pix_o <= DW'(tot_d >> NORM_SHIFT);
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> $past(win_vld, 3)); // R5

endmodule

// File: rtl/gauss3_stream.sv
module gauss3_stream
    import g3_pkg::*;
#(
    parameter int IMG_W = 640,
    parameter int IMG_H = 480,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [PIX_W-1:0] out_pix,
    output logic             out_valid
);
    localparam int COL_W  = $clog2(IMG_W);
    localparam int ROW_W  = $clog2(IMG_H);
    localparam int FILL_W = $clog2(IMG_W + 2);
    localparam int NPIX   = IMG_W * IMG_H;
    localparam int CNT_W  = $clog2(NPIX + 1);
    localparam logic [COL_W-1:0]  COL_LAST   = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST   = ROW_W'(IMG_H - 1);
    localparam logic [FILL_W-1:0] FILL_FULL  = FILL_W'(IMG_W + 1);
    localparam logic [FILL_W-1:0] FLUSH_LAST = FILL_W'(IMG_W);

    g3_state_e         state_q, state_d;
    logic              sof_hit, adv, last_in, cen_ok;
    logic [PIX_W-1:0]  smp;
    logic [COL_W-1:0]  ic_q, cc_q;
    logic [ROW_W-1:0]  ir_q, cr_q;
    logic [FILL_W-1:0] fill_q, fc_q;
    logic              win_vld_q;
    g3_border_t        border_q;
    logic [CNT_W-1:0]  cen_cnt_q;

    logic [KDIM-1:0][KDIM-1:0][PIX_W-1:0] win;

    // A frame start is honoured everywhere except during the drain.
    assign sof_hit = in_valid && in_sof && (state_q != ST_FLUSH);
    assign last_in = (ir_q == ROW_LAST) && (ic_q == COL_LAST);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and per-cycle controls.
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        smp     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sof_hit) begin
                    state_d = ST_RUN;
                    adv     = 1'b1;
                    smp     = in_pix;
                end
            end
            ST_RUN: begin
                if (in_valid) begin
                    adv = 1'b1;
                    smp = in_pix;
                    if (!in_sof && last_in) begin
                        state_d = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                adv = 1'b1;
                if (fc_q == FLUSH_LAST) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // The centre trails the newest sample by one row and one column.
    assign cen_ok = adv && !sof_hit && (fill_q == FILL_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ic_q      <= '0;
            ir_q      <= '0;
            cc_q      <= '0;
            cr_q      <= '0;
            fill_q    <= '0;
            fc_q      <= '0;
            win_vld_q <= 1'b0;
            border_q  <= '0;
            cen_cnt_q <= '0;
        end else begin
            if (sof_hit) begin
                ic_q <= COL_W'(1);
                ir_q <= '0;
            end else if (state_q == ST_RUN && in_valid) begin
                if (ic_q == COL_LAST) begin
                    ic_q <= '0;
                    ir_q <= ir_q + 1'b1;
                end else begin
                    ic_q <= ic_q + 1'b1;
                end
            end

            if (sof_hit) begin
                fill_q <= FILL_W'(1);
            end else if (adv && fill_q != FILL_FULL) begin
                fill_q <= fill_q + 1'b1;
            end

            if (sof_hit) begin
                cc_q      <= '0;
                cr_q      <= '0;
                cen_cnt_q <= '0;
            end else if (cen_ok) begin
                cen_cnt_q <= cen_cnt_q + 1'b1;
                if (cc_q == COL_LAST) begin
                    cc_q <= '0;
                    cr_q <= cr_q + 1'b1;
                end else begin
                    cc_q <= cc_q + 1'b1;
                end
            end

            fc_q <= (state_q == ST_FLUSH) ? fc_q + 1'b1 : '0;

            win_vld_q    <= cen_ok;
            border_q.top <= (cr_q == '0);
            border_q.bot <= (cr_q == ROW_LAST);
            border_q.lft <= (cc_q == '0);
            border_q.rgt <= (cc_q == COL_LAST);
        end
    end

    g3_window #(
        .LINE (IMG_W),
        .DW   (PIX_W)
    ) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .din   (smp),
        .win   (win)
    );

    g3_kernel #(
        .DW (PIX_W)
    ) u_kernel (
        .clk     (clk),
        .rst_n   (rst_n),
        .win     (win),
        .win_vld (win_vld_q),
        .border  (border_q),
        .pix_o   (out_pix),
        .vld_o   (out_valid)
    );

    AST_IDLE_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sof_hit) |=> !win_vld_q); // R7

    AST_SOF_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sof_hit |=> (state_q == ST_RUN)); // R8

    AST_RUN_NEEDS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> $past(in_valid && in_sof)); // R1

    AST_FRAME_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cen_cnt_q <= CNT_W'(NPIX)); // R4

    AST_FRAME_COUNT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH && state_d == ST_IDLE) |=> (cen_cnt_q == CNT_W'(NPIX))); // R4

    AST_FLUSH_DRIVES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> win_vld_q); // R9

endmodule

// File: tb/tb_gauss3_stream.sv
module tb_gauss3_stream;
    localparam int W    = 8;
    localparam int H    = 5;
    localparam int NPIX = W * H;

    // Flat-image vectors: {value, corner, border, interior}.
    localparam logic [31:0] FLAT_TAB [5] = '{
        {8'd0,   8'd0,   8'd0,   8'd0},
        {8'd255, 8'd143, 8'd191, 8'd255},
        {8'd16,  8'd9,   8'd12,  8'd16},
        {8'd100, 8'd56,  8'd75,  8'd100},
        {8'd7,   8'd4,   8'd5,   8'd7}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] in_pix;
    logic       in_valid;
    logic       in_sof;
    logic [7:0] out_pix;
    logic       out_valid;

    always #4 clk = ~clk;

    gauss3_stream #(
        .IMG_W (W),
        .IMG_H (H),
        .PIX_W (8)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_pix    (in_pix),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .out_pix   (out_pix),
        .out_valid (out_valid)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int t0     = 0;

    logic [7:0] img [2][H][W];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    int         got_cyc[$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got_q.push_back(out_pix);
            got_cyc.push_back(cyc);
        end
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int gold(input int s, input int r, input int c);
        int acc;
        acc = 0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                int rr;
                int cc;
                int wt;
                rr = r + dr;
                cc = c + dc;
                wt = ((dr == 0) ? 2 : 1) * ((dc == 0) ? 2 : 1);
                if (rr >= 0 && rr < H && cc >= 0 && cc < W)
                    acc += wt * int'(img[s][rr][cc]);
            end
        end
        return (acc + 8) >>> 4;
    endfunction

    task automatic fill_img(input int s, input bit rnd, input logic [15:0] seed, input int flat);
        logic [15:0] lf;
        lf = seed;
        for (int k = 0; k < NPIX; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            img[s][k / W][k % W] = rnd ? lf[7:0] : 8'(flat);
        end
    endtask

    task automatic push_gold(input int s, input int n);
        for (int k = 0; k < n; k++) exp_q.push_back(8'(gold(s, k / W, k % W)));
    endtask

    task automatic clear_all();
        exp_q.delete();
        got_q.delete();
        got_cyc.delete();
    endtask

    task automatic drive_pixels(input int s, input int count, input bit with_sof, input int gap_mod);
        for (int k = 0; k < count; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_pix   = img[s][k / W][k % W];
            in_sof   = with_sof && (k == 0);
            if (k == 0) t0 = cyc;
            if (gap_mod != 0 && (k % gap_mod) == 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_sof   = 1'b0;
                in_pix   = 8'hA5;
            end
        end
    endtask

    task automatic drive_idle(input int n, input bit v, input bit s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = v;
            in_sof   = s;
            in_pix   = 8'(i * 37 + 11);
        end
    endtask

    task automatic compare(input string req);
        check(req, "output count", got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(req, $sformatf("pixel %0d", i), int'(got_q[i]), int'(exp_q[i]));
    endtask

    initial begin
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_pix   = '0;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        drive_idle(6, 1'b0, 1'b0);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "outputs after reset", got_q.size(), 0);

        // Flat-image vector table: border handling and normalisation (R2, R3, R4).
        for (int e = 0; e < 5; e++) begin
            fill_img(0, 1'b0, 16'h1, int'(FLAT_TAB[e][31:24]));
            clear_all();
            drive_pixels(0, NPIX, 1'b1, 0);
            drive_idle(W + 12, 1'b0, 1'b0);
            check("R4", "flat frame count", got_q.size(), NPIX);
            if (got_q.size() == NPIX) begin
                check("R3", "top-left corner", int'(got_q[0]), int'(FLAT_TAB[e][23:16]));
                check("R3", "top border", int'(got_q[3]), int'(FLAT_TAB[e][15:8]));
                check("R2", "interior", int'(got_q[2 * W + 3]), int'(FLAT_TAB[e][7:0]));
                check("R3", "bottom-right corner", int'(got_q[NPIX - 1]), int'(FLAT_TAB[e][23:16]));
            end
        end

        // Gap-free random frame; junk with start-of-frame during the drain (R5, R9, R11).
        fill_img(0, 1'b1, 16'hACE1, 0);
        clear_all();
        push_gold(0, NPIX);
        drive_pixels(0, NPIX, 1'b1, 0);
        drive_idle(W + 1, 1'b1, 1'b1);
        drive_idle(W + 12, 1'b0, 1'b0);
        compare("R9");
        if (got_cyc.size() > 0) begin
            check("R5", "first output latency", got_cyc[0] - t0, W + 5);
            check("R11", "output span", got_cyc[got_cyc.size() - 1] - got_cyc[0], NPIX - 1);
        end

        // Idle gaps inside the frame (R6).
        fill_img(0, 1'b1, 16'h1D2B, 0);
        clear_all();
        push_gold(0, NPIX);
        drive_pixels(0, NPIX, 1'b1, 3);
        drive_idle(W + 12, 1'b0, 1'b0);
        compare("R6");

        // Stray pixels in IDLE without start-of-frame (R7).
        clear_all();
        drive_pixels(0, 10, 1'b0, 0);
        drive_idle(W + 12, 1'b0, 1'b0);
        check("R7", "no output from stray pixels", got_q.size(), 0);
        fill_img(0, 1'b1, 16'h5A5A, 0);
        push_gold(0, NPIX);
        drive_pixels(0, NPIX, 1'b1, 0);
        drive_idle(W + 12, 1'b0, 1'b0);
        compare("R7");

        // Restart in the middle of a frame (R8).
        fill_img(0, 1'b1, 16'h7777, 0);
        fill_img(1, 1'b1, 16'h0F0F, 0);
        clear_all();
        push_gold(0, W + 2);
        push_gold(1, NPIX);
        drive_pixels(0, 2 * W + 3, 1'b1, 0);
        drive_pixels(1, NPIX, 1'b1, 0);
        drive_idle(W + 12, 1'b0, 1'b0);
        compare("R8");

        // Back-to-back frames right after the drain (R10).
        fill_img(0, 1'b0, 16'h1, 255);
        fill_img(1, 1'b1, 16'h3C3C, 0);
        clear_all();
        push_gold(0, NPIX);
        push_gold(1, NPIX);
        drive_pixels(0, NPIX, 1'b1, 0);
        drive_idle(W + 1, 1'b0, 1'b0);
        drive_pixels(1, NPIX, 1'b1, 0);
        drive_idle(W + 12, 1'b0, 1'b0);
        compare("R10");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule